// File: doc/BRIEF.md
# Bipolar Line Code Violation Monitor

This block watches a received alternate-mark-inversion line. Each bit period it takes one positive-pulse strobe and one negative-pulse strobe, sampled on the bit clock. It decides whether that bit period holds a coding error. The line type (T1 or E1) and a substitution-decoding enable choose which violations count. With decoding on in T1, the two violations inside a valid eight-zero substitution pattern are not counted. With decoding on in E1, only back-to-back violations of the same polarity are counted.

Every error gives a one-cycle strobe and is added to a 16-bit saturating counter. A latched status flag rises on an error and stays high for a programmable time. A read-and-clear pulse copies the running count into a holding register and restarts the count. All symbols pass through an eight-stage delay line, so the same latency applies in every mode.

Top module: `lcv_detector`

## Requirements
- R1: While reset is asserted and right after it, violStrobe and violStatus are 0 and countOut is 0.
- R2: A bit period presented before clock edge k is reflected on violStrobe, on the counter and on violStatus right after edge k+8, in every mode.
- R3: A mark is a period with exactly one of posPulse or negPulse high, and its polarity is positive when posPulse is high. A bipolar violation is a mark whose polarity matches the last mark, however many zeros lie between them. The first mark after reset only sets the reference.
- R4: With zcsEn low, in either line mode, every bipolar violation is an error, including violations inside substitution patterns.
- R5: In T1 (modeE1 low) with zcsEn high, the two violations of a pattern zero-zero-zero-V-B-zero-V-B are not errors. V has the polarity of the preceding mark and B the opposite. A pattern with fewer leading zeros is not exempt.
- R6: In E1 (modeE1 high) with zcsEn high, a bipolar violation is an error only when its polarity matches the previous bipolar violation. The first violation after reset is never an error.
- R7: A period with both posPulse and negPulse high is one error in every mode and leaves the mark polarity reference unchanged.
- R8: holdSel selects how long violStatus is held: 2'b01 holds it 1 cycle, 2'b10 holds it 8 cycles, 2'b11 holds it 64 cycles. Each count starts with the strobe cycle and restarts on every new error.
- R9: The running count is 16 bits wide and stays at 16'hFFFF once it gets there.
- R10: A readClr pulse copies the running count into countOut and clears the count in the same edge. An error at that same edge leaves the new count at 1.
- R11: With holdSel 2'b00, violStatus stays high until a readClr edge with no error at that edge clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rstN | input | 1 | Asynchronous reset, active low |
| posPulse | input | 1 | Positive mark strobe for this bit period |
| negPulse | input | 1 | Negative mark strobe for this bit period |
| modeE1 | input | 1 | 1 selects E1 rules, 0 selects T1 rules |
| zcsEn | input | 1 | Substitution-aware classification enable |
| holdSel | input | 2 | Status hold: 00 until read, 01 one, 10 eight, 11 sixty-four cycles |
| readClr | input | 1 | Capture the count into countOut and clear it |
| violStrobe | output | 1 | One-cycle pulse for each counted error |
| violStatus | output | 1 | Latched violation status |
| countOut | output | 16 | Count captured at the last readClr |

## Verification
The case hardest to reach from the pins is saturation. It takes 65535 errors before the count stops at all ones. The bench drives a double-pulse period every bit, which is an error each cycle in any mode, and then reads the result through countOut. Two other cases need the nine-edge latency counted exactly. One is a read that lands on the same edge as an error. The other is a substitution pattern whose exemption depends on the polarity of the mark before it. The bench handles both by scheduling readClr against the known latency and by starting each pattern from reset with a chosen leading mark.

// File: rtl/lcv_pkg.sv
package lcv_pkg;

  // Delay line length equals the substitution pattern length.
  localparam int PIPE_DEPTH = 8;
  // Stage indices holding the two V pulses when a full pattern is aligned.
  localparam int V_FIRST_POS  = 4;
  localparam int V_SECOND_POS = 1;

  typedef struct packed {
    logic pos;
    logic neg;
  } lineSym_t;

  typedef struct packed {
    logic err;
    logic clr;
  } lcvStrobe_t;

  typedef enum logic [1:0] {
    HOLD_UNTIL_READ = 2'b00,
    HOLD_ONE        = 2'b01,
    HOLD_MID_SEL    = 2'b10,
    HOLD_LONG_SEL   = 2'b11
  } holdSel_e;

  function automatic lineSym_t markOf(input logic pol);
    return lineSym_t'({pol, ~pol});
  endfunction

endpackage

// File: rtl/lcv_ctrl.sv
module lcv_ctrl
  import lcv_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       posPulse,
  input  logic       negPulse,
  input  logic       modeE1,
  input  logic       zcsEn,
  input  logic       readClr,
  output lcvStrobe_t strobes
);

  lineSym_t                pipe [PIPE_DEPTH];
  logic [PIPE_DEPTH-1:0]   supFlag;
  logic                    refPol;
  logic                    refValid;
  logic                    violPol;
  logic                    violValid;

  lineSym_t oldest;
  logic     isMark;
  logic     isDouble;
  logic     markPol;
  logic     bpv;
  logic     b8zsHit;
  logic     errNow;

  always_comb begin
    oldest   = pipe[PIPE_DEPTH-1];
    isMark   = oldest.pos ^ oldest.neg;
    isDouble = oldest.pos & oldest.neg;
    markPol  = oldest.pos;
    bpv      = isMark && refValid && (markPol == refPol);
  end

  // Pattern 000VB0VB, oldest symbol in the highest stage.
  always_comb begin
    b8zsHit = refValid
           && (pipe[7] == '0) && (pipe[6] == '0) && (pipe[5] == '0)
           && (pipe[V_FIRST_POS]  == markOf(refPol))
           && (pipe[3]            == markOf(~refPol))
           && (pipe[2] == '0)
           && (pipe[V_SECOND_POS] == markOf(~refPol))
           && (pipe[0]            == markOf(refPol));
  end

  always_comb begin
    unique case ({modeE1, zcsEn})
      2'b01:   errNow = (bpv && !supFlag[PIPE_DEPTH-1]) || isDouble;
      2'b11:   errNow = (bpv && violValid && (markPol == violPol)) || isDouble;
      default: errNow = bpv || isDouble;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < PIPE_DEPTH; i++) pipe[i] <= '0;
      supFlag   <= '0;
      refPol    <= 1'b0;
      refValid  <= 1'b0;
      violPol   <= 1'b0;
      violValid <= 1'b0;
    end else begin
      pipe[0]    <= lineSym_t'({posPulse, negPulse});
      supFlag[0] <= 1'b0;
      for (int i = 1; i < PIPE_DEPTH; i++) begin
        pipe[i]    <= pipe[i-1];
        supFlag[i] <= supFlag[i-1]
                   | (b8zsHit && ((i - 1 == V_FIRST_POS) || (i - 1 == V_SECOND_POS)));
      end
      if (isMark) begin
        refPol   <= markPol;
        refValid <= 1'b1;
      end
      if (bpv) begin
        violPol   <= markPol;
        violValid <= 1'b1;
      end
    end
  end

  assign strobes.err = errNow;
  assign strobes.clr = readClr;

endmodule

// File: rtl/lcv_datapath.sv
module lcv_datapath
  import lcv_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int HOLD_MID  = 8,
  parameter int HOLD_LONG = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       holdSel,
  input  lcvStrobe_t       strobes,
  output logic             violStrobe,
  output logic             violStatus,
  output logic [CNT_W-1:0] countOut,
  output logic [CNT_W-1:0] liveCount
);

  localparam int TIMER_W = (HOLD_LONG > 2) ? $clog2(HOLD_LONG) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [TIMER_W-1:0] holdTimer;
  logic [TIMER_W-1:0] holdLoad;

  always_comb begin
    unique case (holdSel_e'(holdSel))
      HOLD_MID_SEL:  holdLoad = TIMER_W'(HOLD_MID - 1);
      HOLD_LONG_SEL: holdLoad = TIMER_W'(HOLD_LONG - 1);
      default:       holdLoad = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      violStrobe <= 1'b0;
      liveCount  <= '0;
      countOut   <= '0;
    end else begin
      violStrobe <= strobes.err;
      if (strobes.clr) begin
        countOut  <= liveCount;
        liveCount <= CNT_W'(strobes.err);
      end else if (strobes.err && (liveCount != CNT_MAX)) begin
        liveCount <= liveCount + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      violStatus <= 1'b0;
      holdTimer  <= '0;
    end else if (strobes.err) begin
      violStatus <= 1'b1;
      holdTimer  <= holdLoad;
    end else if (holdSel_e'(holdSel) == HOLD_UNTIL_READ) begin
      if (strobes.clr) violStatus <= 1'b0;
    end else if (violStatus) begin
      if (holdTimer == '0) violStatus <= 1'b0;
      else                 holdTimer  <= holdTimer - 1'b1;
    end
  end

endmodule

// File: rtl/lcv_detector.sv
module lcv_detector
  import lcv_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int HOLD_MID  = 8,
  parameter int HOLD_LONG = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             posPulse,
  input  logic             negPulse,
  input  logic             modeE1,
  input  logic             zcsEn,
  input  logic [1:0]       holdSel,
  input  logic             readClr,
  output logic             violStrobe,
  output logic             violStatus,
  output logic [CNT_W-1:0] countOut
);

  lcvStrobe_t       strobes;
  logic [CNT_W-1:0] liveCount;

  lcv_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .posPulse (posPulse),
    .negPulse (negPulse),
    .modeE1   (modeE1),
    .zcsEn    (zcsEn),
    .readClr  (readClr),
    .strobes  (strobes)
  );

  lcv_datapath #(
    .CNT_W     (CNT_W),
    .HOLD_MID  (HOLD_MID),
    .HOLD_LONG (HOLD_LONG)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .holdSel    (holdSel),
    .strobes    (strobes),
    .violStrobe (violStrobe),
    .violStatus (violStatus),
    .countOut   (countOut),
    .liveCount  (liveCount)
  );

endmodule

// File: rtl/lcv_detector_sva.sv
module lcv_detector_sva #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             readClr,
  input logic [1:0]       holdSel,
  input logic             violStrobe,
  input logic             violStatus,
  input logic [CNT_W-1:0] countOut,
  input logic [CNT_W-1:0] liveCount
);

  p_strobe_sets_status_r8: assert property (@(posedge clk) disable iff (!rstN)
    violStrobe |-> violStatus);

  p_one_bit_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (holdSel == 2'b01 && $past(holdSel) == 2'b01 && !$past(violStatus))
      |-> (violStatus == violStrobe));

  p_count_saturates_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!readClr && liveCount == {CNT_W{1'b1}}) |=> (liveCount == {CNT_W{1'b1}}));

  p_read_captures_r10: assert property (@(posedge clk) disable iff (!rstN)
    readClr |=> (countOut == $past(liveCount) && liveCount <= CNT_W'(1)));

  p_until_read_r11: assert property (@(posedge clk) disable iff (!rstN)
    (holdSel == 2'b00 && violStatus && !readClr) |=> violStatus);

endmodule

bind lcv_detector lcv_detector_sva #(.CNT_W(CNT_W)) u_sva (
  .clk        (clk),
  .rstN       (rstN),
  .readClr    (readClr),
  .holdSel    (holdSel),
  .violStrobe (violStrobe),
  .violStatus (violStatus),
  .countOut   (countOut),
  .liveCount  (liveCount)
);

// File: tb/lcv_detector_test.sv
`timescale 1ns/1ps
module lcv_detector_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        posPulse = 1'b0;
  logic        negPulse = 1'b0;
  logic        modeE1 = 1'b0;
  logic        zcsEn = 1'b0;
  logic [1:0]  holdSel = 2'b01;
  logic        readClr = 1'b0;
  logic        violStrobe;
  logic        violStatus;
  logic [15:0] countOut;

  int checksRun = 0;
  int checksFailed = 0;

  logic [31:0] gotMask;
  int          statusCycles;
  int          clrAt;
  logic        statAfterClr;
  logic [15:0] countAfterClr;

  always #2 clk = ~clk;

  lcv_detector uut (
    .clk        (clk),
    .rstN       (rstN),
    .posPulse   (posPulse),
    .negPulse   (negPulse),
    .modeE1     (modeE1),
    .zcsEn      (zcsEn),
    .holdSel    (holdSel),
    .readClr    (readClr),
    .violStrobe (violStrobe),
    .violStatus (violStatus),
    .countOut   (countOut)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checksRun++;
    if (!ok) begin
      checksFailed++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic doReset(input logic e1, input logic zcs, input logic [1:0] hs);
    @(negedge clk);
    rstN = 1'b0; posPulse = 1'b0; negPulse = 1'b0; readClr = 1'b0;
    modeE1 = e1; zcsEn = zcs; holdSel = hs;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  // Symbol i is driven before edge i; its result is visible at loop index i+9.
  task automatic runPattern(input string s, input int tail);
    int len = s.len();
    gotMask = '0;
    statusCycles = 0;
    for (int i = 0; i <= len + 8 + tail; i++) begin
      @(negedge clk);
      if (i >= 9 && (i - 9) < 32) gotMask[i-9] = violStrobe;
      if (violStatus) statusCycles++;
      if (clrAt >= 0 && i == clrAt + 1) begin
        statAfterClr  = violStatus;
        countAfterClr = countOut;
      end
      readClr = (i == clrAt);
      if (i < len) begin
        case (s[i])
          "P":     begin posPulse = 1'b1; negPulse = 1'b0; end
          "N":     begin posPulse = 1'b0; negPulse = 1'b1; end
          "D":     begin posPulse = 1'b1; negPulse = 1'b1; end
          default: begin posPulse = 1'b0; negPulse = 1'b0; end
        endcase
      end else begin
        posPulse = 1'b0; negPulse = 1'b0;
      end
    end
    readClr = 1'b0;
    clrAt = -1;
  endtask

  task automatic pulseRead();
    @(negedge clk); readClr = 1'b1;
    @(negedge clk); readClr = 1'b0;
  endtask

  task automatic patternCase(input logic e1, input logic zcs, input string s,
                             input logic [31:0] expMask, input string req);
    doReset(e1, zcs, 2'b01);
    clrAt = -1;
    runPattern(s, 2);
    check(gotMask == expMask, req, {"error positions for ", s}, gotMask, expMask);
  endtask

  task automatic testReset();
    doReset(1'b0, 1'b0, 2'b01);
    @(negedge clk);
    check(violStrobe == 1'b0, "R1", "strobe after reset", 32'(violStrobe), 32'h0);
    check(violStatus == 1'b0, "R1", "status after reset", 32'(violStatus), 32'h0);
    check(countOut == 16'h0, "R1", "countOut after reset", 32'(countOut), 32'h0);
  endtask

  task automatic testBasic();
    // R2 timing is built into runPattern's sampling; R3 polarity tracking.
    patternCase(1'b0, 1'b0, "PNZPZZPNN", 32'h140, "R3");
    patternCase(1'b0, 1'b0, "ZZPZZZP", 32'h40, "R2");
    patternCase(1'b1, 1'b0, "NZZZZZZZZZZZZN", 32'h2000, "R3");
  endtask

  task automatic testT1();
    patternCase(1'b0, 1'b0, "PZZZPNZNPNN", 32'h490, "R4");
    patternCase(1'b0, 1'b1, "PZZZPNZNPNN", 32'h400, "R5");
    patternCase(1'b0, 1'b1, "NZZZNPZPN", 32'h0, "R5");
    patternCase(1'b0, 1'b1, "PZZPNZNP", 32'h48, "R5");
  endtask

  task automatic testE1();
    patternCase(1'b1, 1'b0, "PZZZPNZZNPZZZPZP", 32'hA110, "R4");
    patternCase(1'b1, 1'b1, "PZZZPNZZNPZZZPZP", 32'h8000, "R6");
    patternCase(1'b1, 1'b1, "PP", 32'h0, "R6");
  endtask

  task automatic testDouble();
    patternCase(1'b0, 1'b0, "PDNDPP", 32'h2A, "R7");
    doReset(1'b1, 1'b1, 2'b01);
    clrAt = -1;
    runPattern("DD", 2);
    check(gotMask == 32'h3, "R7", "double pulses in E1 decoded mode", gotMask, 32'h3);
    pulseRead();
    check(countOut == 16'd2, "R7", "double pulse counted once", 32'(countOut), 32'd2);
  endtask

  task automatic holdCase(input logic [1:0] hs, input string s, input int tail,
                          input int expCycles, input string what);
    doReset(1'b0, 1'b0, hs);
    clrAt = -1;
    runPattern(s, tail);
    check(statusCycles == expCycles, "R8", what, 32'(statusCycles), 32'(expCycles));
  endtask

  task automatic testHold();
    holdCase(2'b01, "PP", 20, 1, "hold one cycle");
    holdCase(2'b10, "PP", 20, 8, "hold eight cycles");
    holdCase(2'b11, "PP", 80, 64, "hold sixty-four cycles");
    holdCase(2'b10, "PZPZZP", 20, 11, "hold restarted by second error");
  endtask

  task automatic testUntilRead();
    doReset(1'b0, 1'b0, 2'b00);
    clrAt = -1;
    runPattern("PP", 100);
    check(violStatus == 1'b1, "R11", "status held until read", 32'(violStatus), 32'h1);
    pulseRead();
    check(violStatus == 1'b0, "R11", "status cleared by read", 32'(violStatus), 32'h0);
  endtask

  task automatic testCoincident();
    // Errors register at edges 9, 10 and 11; the read lands on edge 10.
    doReset(1'b0, 1'b0, 2'b00);
    clrAt = 10;
    runPattern("PPPP", 3);
    check(countAfterClr == 16'd1, "R10", "captured count at coincident read",
          32'(countAfterClr), 32'd1);
    check(statAfterClr == 1'b1, "R11", "status kept by coincident error",
          32'(statAfterClr), 32'h1);
    pulseRead();
    check(countOut == 16'd2, "R10", "coincident error kept in new count",
          32'(countOut), 32'd2);
    check(violStatus == 1'b0, "R11", "status cleared by later read",
          32'(violStatus), 32'h0);
  endtask

  task automatic testSaturation();
    doReset(1'b0, 1'b0, 2'b01);
    for (int i = 0; i < 65540; i++) begin
      @(negedge clk);
      posPulse = 1'b1; negPulse = 1'b1;
    end
    @(negedge clk);
    posPulse = 1'b0; negPulse = 1'b0;
    repeat (12) @(negedge clk);
    pulseRead();
    check(countOut == 16'hFFFF, "R9", "count saturates", 32'(countOut), 32'hFFFF);
    pulseRead();
    check(countOut == 16'h0, "R10", "count cleared by read", 32'(countOut), 32'h0);
  endtask

  initial begin
    #640000;
    checksRun++;
    checksFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checksRun - checksFailed, checksRun);
    $finish;
  end

  initial begin
    clrAt = -1;
    testReset();
    testBasic();
    testT1();
    testE1();
    testDouble();
    testHold();
    testUntilRead();
    testCoincident();
    testSaturation();
    $display("%0d/%0d checks passed", checksRun - checksFailed, checksRun);
    $finish;
  end

endmodule